// File: doc/BRIEF.md
# Serial Register Target with Shared-Line Mode

This block is a four-wire serial target that gives a host read and write access to a small bank of 8-bit registers. A transaction begins when the active-low select falls and ends when it rises. The first eight serial clocks carry a command byte. Every later group of eight clocks moves one data byte, either into the bank or out of it. Input data is sampled on rising serial-clock edges, and output data changes on falling edges. All pins are sampled by a faster system clock, so the block has no clock domain of its own.

One mode register in the bank controls two things at the pins. The first is whether read data leaves on the dedicated output pin or on the shared data-in line (three-wire operation). The second is whether the pull-up on the dedicated output stays enabled. A read burst can walk through consecutive registers or keep returning the same one.

Top module: `spi3w_target`

## Requirements
- R1: After reset every register reads 0x00, both output-enables are low and the pull-up enable output is high.
- R2: The command byte is received MSB first: its first bit is the direction (1 = read, 0 = write), its second bit is the increment flag, and its remaining six bits are the register address, most significant bit first.
- R3: A write frame of 16 serial clocks stores the second byte, received MSB first, into the addressed register.
- R4: On a read, the target places the MSB of the addressed register on the output at the falling edge that begins bit 8, and the remaining bits follow on later falling edges. No output-enable is high during the command byte.
- R5: With the increment flag set, each completed data byte moves the address up by one, for both reads and writes.
- R6: With the increment flag clear, every data byte in the frame uses the command address.
- R7: When bit 0 of the mode register at address 0x03 is 1, read data is driven on the shared line output with its enable, and the dedicated output enable stays low.
- R8: When bit 1 of the mode register at address 0x03 is 1, the pull-up enable output is low. Otherwise it is high.
- R9: A select rise in the middle of a byte ends the frame, and the incomplete write byte is discarded.
- R10: An output-enable is high only while select is low and a read data phase is in progress.
- R11: Addresses at or above the bank depth (16 by default) read as 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Frame select, active low |
| spc_i | input | 1 | Serial clock, idles high |
| sdio_i | input | 1 | Serial data in; also the shared line in three-wire mode |
| sdio_o | output | 1 | Read data driven onto the shared line |
| sdio_oe_o | output | 1 | Enable for sdio_o |
| sdo_o | output | 1 | Read data on the dedicated output |
| sdo_oe_o | output | 1 | Enable for sdo_o |
| sdo_pu_en_o | output | 1 | Pull-up enable for the dedicated output |

## Verification
A wrong bit counter or a missed command capture would shift the data one or more bit positions. That error shows on the very next read, and on a write it shows at the readback of the register. Address state that does not advance, or that advances when it should not, appears in the second byte of a burst. A stuck drive flag shows as an enable that is high during the command byte or after select rises. The bench samples both enables at every bit of every frame, so such a flag is caught within one bit time.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [CNT_W-1:0]  bit_cnt;
        logic              first;
        logic [BYTE_W-2:0] shift;
        logic              rw;
        logic              inc;
        addr_t             addr;
        byte_t             tx;
        logic              out_bit;
        logic              drv;
    } frame_st_t;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_n_i,
    input  logic spc_i,
    input  logic din_i,
    output logic cs_hi_o,
    output logic rise_o,
    output logic fall_o,
    output logic din_o
);
    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] spc;
        logic [STAGES-1:0] din;
        logic              spc_prev;
    } sync_st_t;

    sync_st_t d, q;

    always_comb begin
        d          = q;
        d.cs       = {q.cs[STAGES-2:0], cs_n_i};
        d.spc      = {q.spc[STAGES-2:0], spc_i};
        d.din      = {q.din[STAGES-2:0], din_i};
        d.spc_prev = q.spc[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{cs: '1, spc: '1, din: '0, spc_prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign cs_hi_o = q.cs[STAGES-1];
    assign rise_o  = q.spc[STAGES-1] & ~q.spc_prev;
    assign fall_o  = ~q.spc[STAGES-1] & q.spc_prev;
    assign din_o   = q.din[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
    import spi3w_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  cs_hi_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  din_i,
    input  byte_t rd_data_i,
    output addr_t rd_addr_o,
    output logic  wr_en_o,
    output addr_t wr_addr_o,
    output byte_t wr_data_o,
    output logic  out_bit_o,
    output logic  drv_o
);
    localparam frame_st_t RST = '{bit_cnt: '0, first: 1'b1, shift: '0, rw: 1'b0,
                                  inc: 1'b0, addr: '0, tx: '0, out_bit: 1'b0, drv: 1'b0};

    frame_st_t d, q;
    byte_t     full;
    addr_t     next_addr;

    always_comb begin
        d         = q;
        full      = {q.shift, din_i};
        next_addr = q.inc ? addr_t'(q.addr + 1'b1) : q.addr;
        rd_addr_o = q.first ? full[ADDR_W-1:0] : next_addr;
        wr_en_o   = 1'b0;
        wr_addr_o = q.addr;
        wr_data_o = full;
        if (cs_hi_i) begin
            d.bit_cnt = '0;
            d.first   = 1'b1;
            d.drv     = 1'b0;
        end else begin
            if (rise_i) begin
                d.shift   = full[BYTE_W-2:0];
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == CNT_W'(BYTE_W-1)) begin
                    if (q.first) begin
                        d.first = 1'b0;
                        d.rw    = full[BYTE_W-1];
                        d.inc   = full[BYTE_W-2];
                        d.addr  = full[ADDR_W-1:0];
                        d.tx    = rd_data_i;
                    end else begin
                        d.addr = next_addr;
                        if (q.rw) begin
                            d.tx = rd_data_i;
                        end else begin
                            wr_en_o = 1'b1;
                        end
                    end
                end
            end
            if (fall_i && !q.first && q.rw) begin
                d.out_bit = q.tx[BYTE_W-1];
                d.tx      = {q.tx[BYTE_W-2:0], 1'b0};
                d.drv     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= RST;
        end else begin
            q <= d;
        end
    end

    assign out_bit_o = q.out_bit;
    assign drv_o     = q.drv;

    // R4: driving only starts once a read command has been captured
    p_drv_after_read_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.drv) |-> (q.rw && !q.first));

    // R4: the output bit moves only after a falling serial-clock edge
    p_out_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fall_i |=> $stable(q.out_bit));

    // R10: a select rise removes the drive flag on the next cycle
    p_drv_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_hi_i |=> !q.drv);
endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank
    import spi3w_pkg::*;
#(
    parameter int unsigned NREG      = 16,
    parameter int unsigned MODE_ADDR = 3
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_en_i,
    input  addr_t wr_addr_i,
    input  byte_t wr_data_i,
    input  addr_t rd_addr_i,
    output byte_t rd_data_o,
    output logic  three_wire_o,
    output logic  pu_off_o
);
    localparam int unsigned IDX_W = $clog2(NREG);

    byte_t mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        byte_t r_d, r_q;
        always_comb begin
            r_d = r_q;
            if (wr_en_i && wr_addr_i == addr_t'(g)) begin
                r_d = wr_data_i;
            end
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end
        assign mem[g] = r_q;
    end

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_addr_i) < NREG) begin
            rd_data_o = mem[rd_addr_i[IDX_W-1:0]];
        end
    end

    assign three_wire_o = mem[MODE_ADDR][0];
    assign pu_off_o     = mem[MODE_ADDR][1];

    // R8: a mode write takes effect on the pull-up control one cycle later
    p_mode_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == addr_t'(MODE_ADDR)) |=> (pu_off_o == $past(wr_data_i[1])));
endmodule

// File: rtl/spi3w_target.sv
module spi3w_target
    import spi3w_pkg::*;
#(
    parameter int unsigned NREG        = 16,
    parameter int unsigned MODE_ADDR   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_n_i,
    input  logic spc_i,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe_o,
    output logic sdo_o,
    output logic sdo_oe_o,
    output logic sdo_pu_en_o
);
    logic  cs_hi, rise, fall, din;
    logic  wr_en, out_bit, drv, three_wire, pu_off;
    addr_t rd_addr, wr_addr;
    byte_t rd_data, wr_data;

    spi3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .spc_i(spc_i), .din_i(sdio_i),
        .cs_hi_o(cs_hi), .rise_o(rise), .fall_o(fall), .din_o(din)
    );

    spi3w_frame u_frame (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_hi_i(cs_hi), .rise_i(rise), .fall_i(fall),
        .din_i(din), .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .out_bit_o(out_bit), .drv_o(drv)
    );

    spi3w_regbank #(.NREG(NREG), .MODE_ADDR(MODE_ADDR)) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .three_wire_o(three_wire), .pu_off_o(pu_off)
    );

    assign sdo_o       = out_bit;
    assign sdio_o      = out_bit;
    assign sdo_oe_o    = drv & ~three_wire;
    assign sdio_oe_o   = drv & three_wire;
    assign sdo_pu_en_o = ~pu_off;

    // R7: the two data outputs are never enabled together
    p_oe_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sdo_oe_o && sdio_oe_o));
endmodule

// File: tb/spi3w_target_tb.sv
module spi3w_target_tb_top;
    localparam int HALF = 8;
    localparam int NVEC = 8;
    // {address, write data, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h01, 8'h3C, 8'h3C}, {8'h02, 8'hC3, 8'hC3}, {8'h0F, 8'h81, 8'h81},
        {8'h00, 8'hFF, 8'hFF}, {8'h30, 8'h5A, 8'h00}, {8'h3F, 8'h12, 8'h00},
        {8'h0A, 8'h7E, 8'h7E}, {8'h07, 8'h96, 8'h96}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, spc = 1'b1, sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe, sdo_pu_en;
    int   n_chk = 0, n_bad = 0;
    logic [7:0] txb [4];
    logic [7:0] rxb [4];
    bit   cmd_oe, data_oe_miss, wrong_oe;

    always #4 clk = ~clk;

    spi3w_target dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .spc_i(spc), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe),
        .sdo_pu_en_o(sdo_pu_en)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic frame(input bit rd, input bit inc, input logic [5:0] a,
                         input int nb, input bit three, input int abort_bits);
        logic [7:0] cmd;
        int total;
        cmd = {rd, inc, a};
        total = (abort_bits > 0) ? 8 + abort_bits : 8 * (nb + 1);
        cmd_oe = 0; data_oe_miss = 0; wrong_oe = 0;
        cs_n = 1'b0;
        wt(HALF);
        for (int k = 0; k < total; k++) begin
            int b, i;
            logic obit;
            b = k / 8;
            i = 7 - (k % 8);
            spc = 1'b0;
            sdio_i = (b == 0) ? cmd[i] : txb[b-1][i];
            wt(HALF);
            obit = three ? sdio_o : sdo_o;
            if (b > 0) rxb[b-1][i] = obit;
            if (b == 0 && (sdo_oe || sdio_oe)) cmd_oe = 1;
            if (b > 0 && rd && !(three ? sdio_oe : sdo_oe)) data_oe_miss = 1;
            if (b > 0 && rd && (three ? sdo_oe : sdio_oe)) wrong_oe = 1;
            if (b > 0 && !rd && (sdo_oe || sdio_oe)) wrong_oe = 1;
            spc = 1'b1;
            wt(HALF);
        end
        cs_n = 1'b1;
        wt(4 * HALF);
    endtask

    task automatic wr1(input logic [5:0] a, input logic [7:0] v);
        txb[0] = v;
        frame(0, 0, a, 1, 0, 0);
    endtask

    task automatic rd1(input logic [5:0] a, input bit three);
        txb[0] = 8'h00;
        frame(1, 0, a, 1, three, 0);
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1: reset state at the ports
        chk("R1 sdo_oe", {7'd0, sdo_oe}, 8'h00);
        chk("R1 sdio_oe", {7'd0, sdio_oe}, 8'h00);
        chk("R1 pull-up", {7'd0, sdo_pu_en}, 8'h01);
        rd1(6'h04, 0);
        chk("R1 reg value", rxb[0], 8'h00);

        // R2 R3 R11: table of single writes, each read back
        for (int v = 0; v < NVEC; v++) begin
            wr1(VEC[v][21:16], VEC[v][15:8]);
            chk("R3 write no drive", {7'd0, wrong_oe}, 8'h00);
            rd1(VEC[v][21:16], 0);
            chk((VEC[v][23:16] >= 8'h10) ? "R11 unmapped" : "R2 R3 readback",
                rxb[0], VEC[v][7:0]);
            chk("R4 cmd byte oe", {7'd0, cmd_oe}, 8'h00);
            chk("R4 data oe", {7'd0, data_oe_miss}, 8'h00);
        end

        // R5: incrementing burst write then burst read
        txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33;
        frame(0, 1, 6'h08, 3, 0, 0);
        frame(1, 1, 6'h08, 3, 0, 0);
        chk("R5 byte0", rxb[0], 8'h11);
        chk("R5 byte1", rxb[1], 8'h22);
        chk("R5 byte2", rxb[2], 8'h33);

        // R6: fixed-address read and write
        frame(1, 0, 6'h09, 3, 0, 0);
        chk("R6 rd byte0", rxb[0], 8'h22);
        chk("R6 rd byte2", rxb[2], 8'h22);
        txb[0] = 8'h44; txb[1] = 8'h55;
        frame(0, 0, 6'h0C, 2, 0, 0);
        rd1(6'h0C, 0);
        chk("R6 last write wins", rxb[0], 8'h55);
        rd1(6'h0D, 0);
        chk("R6 neighbour untouched", rxb[0], 8'h00);

        // R7: three-wire mode
        wr1(6'h03, 8'h01);
        rd1(6'h0F, 1);
        chk("R7 shared line data", rxb[0], 8'h81);
        chk("R7 shared oe", {7'd0, data_oe_miss}, 8'h00);
        chk("R7 dedicated oe off", {7'd0, wrong_oe}, 8'h00);
        chk("R8 pull-up on", {7'd0, sdo_pu_en}, 8'h01);

        // R8: pull-up disable, four-wire again
        txb[0] = 8'h02;
        frame(0, 0, 6'h03, 1, 1, 0);
        chk("R8 pull-up off", {7'd0, sdo_pu_en}, 8'h00);
        rd1(6'h01, 0);
        chk("R8 four-wire back", rxb[0], 8'h3C);
        wr1(6'h03, 8'h00);
        chk("R8 pull-up restored", {7'd0, sdo_pu_en}, 8'h01);

        // R9: aborted partial write is discarded
        wr1(6'h05, 8'hA5);
        txb[0] = 8'hFF;
        frame(0, 0, 6'h05, 1, 0, 4);
        rd1(6'h05, 0);
        chk("R9 abort keeps value", rxb[0], 8'hA5);

        // R10: enables low between frames
        chk("R10 sdo_oe idle", {7'd0, sdo_oe}, 8'h00);
        chk("R10 sdio_oe idle", {7'd0, sdio_oe}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule